// File: doc/BRIEF.md
# Lock Regime Controller for a Fast-Settling Digital PLL

This block decides which phase-detection path steers a fast-locking digital PLL. Each reference cycle the loop delivers one signed phase-error sample. The controller takes the absolute value of that sample and compares it against two programmable limits. As the error shrinks, it walks the loop through four regimes in a fixed order:

1. a coarse linear detector that counts oscillator cycles;
2. a linear detector that measures time on an inverter delay line;
3. bang-bang detection helped by a proportional-integral-derivative state machine;
4. plain bang-bang detection.

It leaves the third regime once that state machine reports that its derivative gain has decayed to zero. A request to reconfigure the frequency word sends it back to the first regime.

The phase error arrives on a valid/ready interface. The block always accepts a sample, so ready is held high and there is never back-pressure. A cycle without valid is not a sample and cannot move the regime. The thresholds, the derivative-zero flag and the retune request are plain level inputs. The two limits are meant to satisfy coarse > fine; the fine limit is about one inverter delay. The outputs are:

- a one-hot regime vector;
- a 2-bit select for the loop-filter multiplexer;
- the enable for the proportional-integral-derivative state machine.

Top module: `lock_regime_ctrl`

## Requirements
- R1: After reset the regime is the counter regime: mode_onehot = 4'b0001, gain_sel = 0, pid_en = 0.
- R2: Encoding: bit 0 / gain_sel 0 = counter, bit 1 / gain_sel 1 = delay line, bit 2 / gain_sel 2 = bang-bang with PID, bit 3 / gain_sel 3 = plain bang-bang. Exactly one bit of mode_onehot is set, and gain_sel changes in the same cycle as mode_onehot.
- R3: In the counter regime, an accepted sample with |phase_err| < thr_coarse moves the regime to the delay line. The new regime is visible after the next rising clock edge.
- R4: In the delay-line regime, an accepted sample with |phase_err| < thr_fine moves the regime to bang-bang with PID, one clock later.
- R5: In the bang-bang-with-PID regime, an accepted sample while kd_zero is high moves the regime to plain bang-bang, one clock later.
- R6: retune high returns the regime to the counter regime one clock later, from every regime. It takes priority over any advance in the same cycle.
- R7: The regime moves by at most one step per accepted sample. With err_valid low it does not move (except on retune). kd_zero has no effect outside the bang-bang-with-PID regime.
- R8: phase_err is two's complement, and its magnitude is its exact absolute value. For example, -128 at width 8 has magnitude 128. Both comparisons are strict: a magnitude equal to the threshold does not advance.
- R9: pid_en is high exactly while the regime is bang-bang with PID.
- R10: err_ready is always high.
- R11: Plain bang-bang is held whatever the error magnitude, until retune.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_valid | input | 1 | Phase-error sample valid |
| err_ready | output | 1 | Always high; no back-pressure |
| phase_err | input | ERR_W | Signed two's-complement phase error |
| thr_coarse | input | ERR_W | Unsigned limit for leaving the counter regime |
| thr_fine | input | ERR_W | Unsigned limit for leaving the delay-line regime |
| kd_zero | input | 1 | Derivative gain of the PID state machine has reached zero |
| retune | input | 1 | Frequency-word reconfiguration request |
| mode_onehot | output | 4 | One-hot regime |
| gain_sel | output | 2 | Loop-filter multiplexer select, regime index |
| pid_en | output | 1 | Enable for the PID state machine |

## Verification
The regime state drives all three outputs directly. A wrong step therefore shows on gain_sel, mode_onehot and pid_en in the very cycle after the offending sample, with no extra latency. The most telling faults are:

- a skipped or duplicated step;
- a lost sign in the magnitude, which appears only for negative errors and at the most negative code;
- an off-by-one at a threshold;
- a retune that loses priority to a simultaneous advance.

The sweeps drive every error code from each relevant regime, so each of these faults surfaces at the first affected code.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  localparam int unsigned NUM_REGIMES = 4;
  localparam int unsigned SEL_W       = $clog2(NUM_REGIMES);

  typedef enum logic [SEL_W-1:0] {
    RG_COUNT  = 2'd0,
    RG_DLINE  = 2'd1,
    RG_BBPID  = 2'd2,
    RG_BBONLY = 2'd3
  } regime_t;
endpackage

// File: rtl/lrc_abs.sv
module lrc_abs #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] val,
  output logic [W-1:0] mag
);
  // Unsigned result: the most negative code maps to 2**(W-1) without overflow.
  always_comb begin
    if (val[W-1]) mag = (~val) + {{(W-1){1'b0}}, 1'b1};
    else          mag = val;
  end
endmodule

// File: rtl/lrc_cmp.sv
module lrc_cmp #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 2
) (
  input  logic [W-1:0]        mag,
  input  logic [N-1:0][W-1:0] limit,
  output logic [N-1:0]        below
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign below[g] = (mag < limit[g]);
  end
endmodule

// File: rtl/lrc_fsm.sv
module lrc_fsm
  import lrc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sample,
  input  logic    below_coarse,
  input  logic    below_fine,
  input  logic    kd_zero,
  input  logic    retune,
  output regime_t state
);
  regime_t nxt;

  always_comb begin
    nxt = state;
    if (retune) begin
      nxt = RG_COUNT;
    end else if (sample) begin
      unique case (state)
        RG_COUNT:  if (below_coarse) nxt = RG_DLINE;
        RG_DLINE:  if (below_fine)   nxt = RG_BBPID;
        RG_BBPID:  if (kd_zero)      nxt = RG_BBONLY;
        RG_BBONLY: nxt = RG_BBONLY;
        default:   nxt = RG_COUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= RG_COUNT;
    else        state <= nxt;
  end
endmodule

// File: rtl/lock_regime_ctrl.sv
module lock_regime_ctrl
  import lrc_pkg::*;
#(
  parameter int unsigned ERR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   err_valid,
  output logic                   err_ready,
  input  logic [ERR_W-1:0]       phase_err,
  input  logic [ERR_W-1:0]       thr_coarse,
  input  logic [ERR_W-1:0]       thr_fine,
  input  logic                   kd_zero,
  input  logic                   retune,
  output logic [NUM_REGIMES-1:0] mode_onehot,
  output logic [SEL_W-1:0]       gain_sel,
  output logic                   pid_en
);
  localparam int unsigned NUM_LIM = 2;
  localparam int unsigned LIM_C   = 0;
  localparam int unsigned LIM_F   = 1;

  logic [ERR_W-1:0]              err_mag;
  logic [NUM_LIM-1:0][ERR_W-1:0] limits;
  logic [NUM_LIM-1:0]            below;
  regime_t                       state;

  assign err_ready     = 1'b1;
  assign limits[LIM_C] = thr_coarse;
  assign limits[LIM_F] = thr_fine;

  lrc_abs #(.W(ERR_W)) u_abs (
    .val (phase_err),
    .mag (err_mag)
  );

  lrc_cmp #(.W(ERR_W), .N(NUM_LIM)) u_cmp (
    .mag   (err_mag),
    .limit (limits),
    .below (below)
  );

  lrc_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample       (err_valid & err_ready),
    .below_coarse (below[LIM_C]),
    .below_fine   (below[LIM_F]),
    .kd_zero      (kd_zero),
    .retune       (retune),
    .state        (state)
  );

  // All outputs decode the single state register, so they change together.
  assign mode_onehot = {{(NUM_REGIMES-1){1'b0}}, 1'b1} << state;
  assign gain_sel    = state;
  assign pid_en      = (state == RG_BBPID);
endmodule

// File: rtl/lrc_chk.sv
module lrc_chk #(
  parameter int unsigned ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             err_valid,
  input logic             err_ready,
  input logic [ERR_W-1:0] phase_err,
  input logic [ERR_W-1:0] thr_coarse,
  input logic [ERR_W-1:0] thr_fine,
  input logic             kd_zero,
  input logic             retune,
  input logic [3:0]       mode_onehot,
  input logic [1:0]       gain_sel,
  input logic             pid_en
);
  logic [ERR_W-1:0] cmag;
  assign cmag = phase_err[ERR_W-1] ? (ERR_W'(0) - phase_err) : phase_err;

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_onehot) == 1);
  p_sel_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_onehot == (4'b0001 << gain_sel));
  p_coarse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_sel == 2'd0 && err_valid && !retune && cmag < thr_coarse) |=> gain_sel == 2'd1);
  p_fine_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_sel == 2'd1 && err_valid && !retune && cmag < thr_fine) |=> gain_sel == 2'd2);
  p_kd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_sel == 2'd2 && err_valid && kd_zero && !retune) |=> gain_sel == 2'd3);
  p_retune_r6: assert property (@(posedge clk) disable iff (!rst_n)
    retune |=> gain_sel == 2'd0);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_valid && !retune) |=> $stable(gain_sel));
  p_pid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pid_en == (gain_sel == 2'd2));
  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_ready);
  p_final_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_sel == 2'd3 && !retune) |=> gain_sel == 2'd3);
endmodule

bind lock_regime_ctrl lrc_chk #(.ERR_W(ERR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .err_valid   (err_valid),
  .err_ready   (err_ready),
  .phase_err   (phase_err),
  .thr_coarse  (thr_coarse),
  .thr_fine    (thr_fine),
  .kd_zero     (kd_zero),
  .retune      (retune),
  .mode_onehot (mode_onehot),
  .gain_sel    (gain_sel),
  .pid_en      (pid_en)
);

// File: tb/sim_lock_regime_ctrl.sv
`timescale 1ns/1ps
module sim_lock_regime_ctrl;
  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         err_valid = 1'b0;
  logic         err_ready;
  logic [W-1:0] phase_err = '0;
  logic [W-1:0] thr_coarse = '0;
  logic [W-1:0] thr_fine = '0;
  logic         kd_zero = 1'b0;
  logic         retune = 1'b0;
  logic [3:0]   mode_onehot;
  logic [1:0]   gain_sel;
  logic         pid_en;

  int checks = 0;
  int fails  = 0;
  int em     = 0;
  int thr_c  = 40;
  int thr_f  = 9;

  always #2.5 clk = ~clk;

  lock_regime_ctrl #(.ERR_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_ready(err_ready),
    .phase_err(phase_err), .thr_coarse(thr_coarse), .thr_fine(thr_fine),
    .kd_zero(kd_zero), .retune(retune), .mode_onehot(mode_onehot),
    .gain_sel(gain_sel), .pid_en(pid_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int e, input bit v, input bit kd, input bit rt, input string tag);
    int m;
    int nx;
    m  = (e < 0) ? -e : e;
    nx = em;
    if (rt) nx = 0;
    else if (v) begin
      case (em)
        0: if (m < thr_c) nx = 1;
        1: if (m < thr_f) nx = 2;
        2: if (kd) nx = 3;
        default: nx = em;
      endcase
    end
    thr_coarse = thr_c[W-1:0];
    thr_fine   = thr_f[W-1:0];
    phase_err  = e[W-1:0];
    err_valid  = v;
    kd_zero    = kd;
    retune     = rt;
    @(negedge clk);
    err_valid = 1'b0;
    kd_zero   = 1'b0;
    retune    = 1'b0;
    em = nx;
    chk({tag, " gain_sel"}, int'(gain_sel), em);
    chk({tag, " onehot R2"}, int'(mode_onehot), 1 << em);
    chk({tag, " pid_en R9"}, int'(pid_en), (em == 2) ? 1 : 0);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 gain_sel", int'(gain_sel), 0);
    chk("R1 onehot", int'(mode_onehot), 1);
    chk("R1 pid_en", int'(pid_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(gain_sel), 0);
    chk("R10 ready", int'(err_ready), 1);

    // Sweep every code through the regime ladder.
    for (int e = -128; e < 128; e++) begin
      step(0, 1'b0, 1'b0, 1'b1, "R6 retune");
      step(e, 1'b0, 1'b1, 1'b0, "R7 no valid");
      step(e, 1'b1, 1'b1, 1'b0, "R3 coarse/R7 one step");
      if (em == 1) begin
        step(e, 1'b1, 1'b0, 1'b0, "R4 fine");
        if (em == 2) begin
          step(e, 1'b0, 1'b1, 1'b0, "R7 hold");
          step(e, 1'b1, 1'b0, 1'b0, "R5 kd low");
          step(e, 1'b1, 1'b1, 1'b0, "R5 kd high");
          step(127, 1'b1, 1'b1, 1'b0, "R11 hold large");
          step(-128, 1'b1, 1'b0, 1'b0, "R11 hold neg");
        end
      end
    end

    // R8 boundaries: most negative code and equality.
    thr_c = 128; step(0, 1'b0, 1'b0, 1'b1, "R6 retune");
    step(-128, 1'b1, 1'b0, 1'b0, "R8 -128 eq 128");
    thr_c = 129; step(-128, 1'b1, 1'b0, 1'b0, "R8 -128 lt 129");
    thr_c = 1; step(0, 1'b0, 1'b0, 1'b1, "R6 retune");
    step(-1, 1'b1, 1'b0, 1'b0, "R8 -1 eq 1");
    thr_c = 255; step(127, 1'b1, 1'b0, 1'b0, "R8 127 lt 255");
    thr_f = 0; step(0, 1'b1, 1'b0, 1'b0, "R8 zero limit");
    thr_f = 5; step(5, 1'b1, 1'b0, 1'b0, "R8 5 eq 5");
    step(-4, 1'b1, 1'b0, 1'b0, "R4 -4 lt 5");

    // R6 priority over a simultaneous advance.
    step(0, 1'b1, 1'b1, 1'b1, "R6 priority bbpid");
    step(0, 1'b1, 1'b1, 1'b1, "R6 priority count");
    step(0, 1'b1, 1'b0, 1'b0, "R3 zero");
    step(0, 1'b1, 1'b0, 1'b0, "R4 zero");
    step(0, 1'b1, 1'b1, 1'b0, "R5 zero");
    step(0, 1'b1, 1'b1, 1'b1, "R6 from plain");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule